// File: doc/BRIEF.md
# Burst Address and Cycle Controller

This block sits in front of a synchronous burst memory array. On every rising clock edge it samples two active-low address strobes, a burst-advance input, three chip enables and the byte-write controls. From these it classifies the cycle as a deselect, a read or a write. It also picks the address source: the external address, the next address of the running burst, or the current address held as a wait cycle.

The results are registered. In the cycle after each edge the block presents the array address, an array enable, one write enable per byte lane and a read-valid flag. A two-bit beat counter drives the two lowest address bits. A mode input selects how they step: linear (add the beat count modulo 4) or interleaved (XOR the start bits with the beat count). The upper address bits are captured when a burst starts and stay fixed until the next start.

The processor strobe has priority over the controller strobe. It is masked by the first chip enable, and it always opens a read. The controller strobe can open a write directly. Both strobes high continues or suspends the running burst.

Top module: `burst_ctl`

## Requirements
- R1: With `order_il` low, each continue cycle with `adv_n` low moves the low two address bits to the start bits plus the beat count, modulo 4 (start 01 gives 01, 10, 11, 00).
- R2: With `order_il` high, the low two address bits of beat k are the start bits XOR k (start 10 gives 10, 11, 00, 01).
- R3: Write decode for an enabled cycle. `gw_n` low sets every bit of `mem_we`. Otherwise, `bwe_n` low sets `mem_we[i]` for each lane i whose `bw_n[i]` is low. Any other combination gives `mem_we` all zero, which is a read.
- R4: `strobe_p_n` low with `sel1_n` low, `sel2` high and `sel3_n` low starts a read burst at `addr_in`. `mem_we` is zero whatever the write controls and `adv_n` are.
- R5: `strobe_p_n` low while `sel1_n` is high is ignored. The cycle behaves as if that strobe were high.
- R6: `strobe_c_n` low with `sel1_n` high is a deselect (`mem_en` low, `mem_we` zero). Later continue cycles keep `mem_en` low until a new start.
- R7: `sel2` and `sel3_n` matter only on strobe cycles. A strobe cycle without full selection is a deselect. On continue cycles all three chip enables are ignored.
- R8: With both strobes inactive and `adv_n` high during a burst, the address is held. The cycle is a read or a write according to R3.
- R9: `strobe_c_n` low with full selection starts a burst at `addr_in`. In that same cycle it writes according to R3.
- R10: After the fourth beat, a further advance returns to the start address.
- R11: The upper `ADDR_W-2` address bits keep the value captured at the start for the whole burst.
- R12: `rd_valid` is high exactly in the cycles where `mem_en` is high and `mem_we` is zero. This holds even when `bwe_n` is low with no lane selected.
- R13: Reset clears `mem_en`, `mem_we`, `rd_valid` and `mem_addr`, and ends any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_in | input | ADDR_W | External address |
| strobe_p_n | input | 1 | Processor address strobe, active low |
| strobe_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | First chip enable, active low |
| sel2 | input | 1 | Second chip enable, active high |
| sel3_n | input | 1 | Third chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NBYTES | Per-lane byte strobes, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| mem_addr | output | ADDR_W | Array address |
| mem_en | output | 1 | Array enable |
| mem_we | output | NBYTES | Per-lane write enables |
| rd_valid | output | 1 | Read cycle indication |

## Verification
The bench uses the default parameters: an 18-bit address and two byte lanes. With these values it can start a burst at an address whose upper bits are all ones and whose low bits begin at 11. That case shows the wrap staying inside the four-beat block and never carrying into the upper bits. Two lanes are enough to show single-lane writes on either lane, both lanes written at once, and the case where byte-write enable is asserted with no lane selected, which must stay a read.

// File: rtl/burst_ctl.sv
module burst_ctl #(
  parameter int ADDR_W = 18,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_p_n,
  input  logic              strobe_c_n,
  input  logic              adv_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic              sel3_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [NBYTES-1:0] bw_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_en,
  output logic [NBYTES-1:0] mem_we,
  output logic              rd_valid
);
  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  logic              act_q, act_d;
  logic              en_d;
  logic [NBYTES-1:0] we_d, wr_mask;
  logic [1:0]        low_d;

  wire sel_ok = !sel1_n && sel2 && !sel3_n;
  wire p_go   = !strobe_p_n && !sel1_n;
  wire c_go   = !p_go && !strobe_c_n;
  wire cont   = !p_go && strobe_c_n;

  assign wr_mask = !gw_n ? {NBYTES{1'b1}} : (!bwe_n ? ~bw_n : '0);

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    act_d  = act_q;
    en_d   = 1'b0;
    we_d   = '0;
    if (p_go || c_go) begin
      if (sel_ok) begin
        base_d = addr_in;
        beat_d = 2'b00;
        act_d  = 1'b1;
        en_d   = 1'b1;
        we_d   = p_go ? '0 : wr_mask;
      end else begin
        act_d = 1'b0;
      end
    end else if (act_q) begin
      en_d = 1'b1;
      we_d = wr_mask;
      if (!adv_n) beat_d = beat_q + 2'd1;
    end
  end

  assign low_d = order_il ? (base_d[1:0] ^ beat_d) : (base_d[1:0] + beat_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      beat_q   <= '0;
      act_q    <= 1'b0;
      mem_addr <= '0;
      mem_en   <= 1'b0;
      mem_we   <= '0;
      rd_valid <= 1'b0;
    end else begin
      base_q   <= base_d;
      beat_q   <= beat_d;
      act_q    <= act_d;
      mem_en   <= en_d;
      mem_we   <= we_d;
      rd_valid <= en_d && (we_d == '0);
      if (en_d) mem_addr <= {base_d[ADDR_W-1:2], low_d};
    end
  end

  assert_we_needs_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we != '0) |-> mem_en);

  assert_pstart_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (p_go && sel_ok) |=> (mem_en && mem_we == '0 && mem_addr == $past(addr_in)));

  assert_cstrobe_desel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_c_n && sel1_n) |=> (!mem_en && mem_we == '0));

  assert_upper_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && act_q) |=> (mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2])));

  assert_rdvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (mem_en && mem_we == '0));

  wire [HI_W-1:0] unused_hi = base_q[ADDR_W-1:2];
endmodule

// File: tb/test_burst_ctl.sv
module test_burst_ctl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [17:0] addr_in;
  logic        strobe_p_n, strobe_c_n, adv_n, sel1_n, sel2, sel3_n, gw_n, bwe_n, order_il;
  logic [1:0]  bw_n;
  logic [17:0] mem_addr;
  logic        mem_en, rd_valid;
  logic [1:0]  mem_we;

  burst_ctl #(.ADDR_W(18), .NBYTES(2)) i_burst_ctl (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .strobe_p_n(strobe_p_n),
    .strobe_c_n(strobe_c_n), .adv_n(adv_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .order_il(order_il),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .rd_valid(rd_valid));

  typedef struct packed {
    logic [17:0] a;
    logic p_n, c_n, adv, s1_n, s2, s3_n, gw, bwe;
    logic [1:0]  bw;
    logic        ord;
    logic        e_en;
    logic [1:0]  e_we;
    logic [17:0] e_addr;
    logic        e_rv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    // R4: processor start, write controls ignored
    '{18'h12345,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h12345,1'b1,4'd4},
    // R7: chip enables ignored while continuing
    '{18'h3FFFF,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h12346,1'b1,4'd7},
    // R1: linear steps
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h12347,1'b1,4'd1},
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h12344,1'b1,4'd1},
    // R10: wrap to start
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h12345,1'b1,4'd10},
    // R8: suspend with global write
    '{18'h00000,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b0, 1'b1,2'b11,18'h12345,1'b0,4'd8},
    // R3: lane 0 only
    '{18'h00000,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,1'b0, 1'b1,2'b01,18'h12345,1'b0,4'd3},
    // R3: lane 1 only while advancing
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b01,1'b0, 1'b1,2'b10,18'h12346,1'b0,4'd3},
    // R3: byte enable with no lane is a read
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,1'b0, 1'b1,2'b00,18'h12347,1'b1,4'd3},
    // R9: controller start writes at once
    '{18'h0ABCE,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1, 1'b1,2'b11,18'h0ABCE,1'b0,4'd9},
    // R2: interleaved steps
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1, 1'b1,2'b00,18'h0ABCF,1'b1,4'd2},
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1, 1'b1,2'b00,18'h0ABCC,1'b1,4'd2},
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1, 1'b1,2'b00,18'h0ABCD,1'b1,4'd2},
    // R10: interleaved wrap
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1, 1'b1,2'b00,18'h0ABCE,1'b1,4'd10},
    // R6: controller strobe with first enable high deselects
    '{18'h00000,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1, 1'b0,2'b00,18'h0ABCE,1'b0,4'd6},
    // R6: continue after deselect has no effect
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b1, 1'b0,2'b00,18'h0ABCE,1'b0,4'd6},
    // R5: blocked processor strobe
    '{18'h12345,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0, 1'b0,2'b00,18'h0ABCE,1'b0,4'd5},
    // R7: processor strobe with second enable low
    '{18'h12345,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'b11,1'b0, 1'b0,2'b00,18'h0ABCE,1'b0,4'd7},
    // R7: controller strobe with third enable high
    '{18'h12345,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b0,2'b00,18'h0ABCE,1'b0,4'd7},
    // R12: controller read start, byte enable without lanes
    '{18'h3FFFF,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'b11,1'b0, 1'b1,2'b00,18'h3FFFF,1'b1,4'd12},
    // R11: wrap does not carry into upper bits
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h3FFFC,1'b1,4'd11},
    // R5: blocked processor strobe lets the burst continue
    '{18'h12345,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h3FFFD,1'b1,4'd5},
    '{18'h00000,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0, 1'b1,2'b00,18'h3FFFE,1'b1,4'd11},
    // R4: processor restart mid-burst, lanes requested but read forced
    '{18'h12345,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,1'b0, 1'b1,2'b00,18'h12345,1'b1,4'd4}
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    addr_in = '0; strobe_p_n = 1; strobe_c_n = 1; adv_n = 1; sel1_n = 1; sel2 = 0;
    sel3_n = 1; gw_n = 1; bwe_n = 1; bw_n = 2'b11; order_il = 0;
  endtask

  task automatic apply(input vec_t v);
    addr_in = v.a; strobe_p_n = v.p_n; strobe_c_n = v.c_n; adv_n = v.adv; sel1_n = v.s1_n;
    sel2 = v.s2; sel3_n = v.s3_n; gw_n = v.gw; bwe_n = v.bwe; bw_n = v.bw; order_il = v.ord;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    rst_n = 0; idle();
    repeat (3) @(negedge clk);
    step();
    // R13: reset state
    chk("R13", "en", {17'b0, mem_en}, 18'h0);
    chk("R13", "we", {16'b0, mem_we}, 18'h0);
    chk("R13", "rv", {17'b0, rd_valid}, 18'h0);
    chk("R13", "addr", mem_addr, 18'h0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk); apply(TBL[i]);
      step();
      chk($sformatf("R%0d row %0d", TBL[i].req, i), "en", {17'b0, mem_en}, {17'b0, TBL[i].e_en});
      chk($sformatf("R%0d row %0d", TBL[i].req, i), "we", {16'b0, mem_we}, {16'b0, TBL[i].e_we});
      chk($sformatf("R%0d row %0d", TBL[i].req, i), "addr", mem_addr, TBL[i].e_addr);
      chk($sformatf("R%0d row %0d", TBL[i].req, i), "rv", {17'b0, rd_valid}, {17'b0, TBL[i].e_rv});
    end

    // R2: interleaved from start 11 gives 11,10,01,00
    @(negedge clk); idle(); order_il = 1; addr_in = 18'h00007; strobe_c_n = 0;
    sel1_n = 0; sel2 = 1; sel3_n = 0;
    step();
    chk("R2", "addr b0", mem_addr, 18'h00007);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); idle(); order_il = 1; adv_n = 0;
      step();
      chk("R2", $sformatf("addr b%0d", k), mem_addr, 18'h00007 ^ 18'(k));
    end

    // R13: reset mid-burst ends the burst
    @(negedge clk); idle(); rst_n = 0; step();
    chk("R13", "en mid", {17'b0, mem_en}, 18'h0);
    chk("R13", "addr mid", mem_addr, 18'h0);
    @(negedge clk); rst_n = 1; idle(); adv_n = 0; gw_n = 0; step();
    chk("R13", "en after", {17'b0, mem_en}, 18'h0);
    chk("R13", "we after", {16'b0, mem_we}, 18'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule